// File: doc/BRIEF.md
# Timer and External Interrupt Flag Register

This block holds one 8-bit control and status register shared by two timers and two external interrupt inputs. It keeps the run enable for each timer, latches each timer's overflow flag, and produces a request flag for each external input. For each input, a trigger-type select decides whether the input is caught on a falling edge or sampled as a low level. The timers count elsewhere and only send overflow pulses here. The interrupt controller receives the request flags and sends back a one-cycle acknowledge pulse for each source when it vectors to that source.

Each external pin is active low and asynchronous, so it passes through a two-flop synchronizer before any detection. In edge mode a request is held until the core acknowledges it. In level mode the request mirrors the synchronized pin, and an acknowledge does not change it. Software reads the whole register and writes it through a simple write port that decodes one address. Software can set or clear the overflow flags. The external request flags are read-only.

Top module: `tmr_irq_ctl`

## Requirements
- R1: After reset every register bit is 0, so rd_data reads 0x00 and all run, overflow and request outputs are low. The register answers only writes to address 0x88.
- R2: rd_data carries the bits in this order, from bit 7 down to bit 0: overflow flag 1, run 1, overflow flag 0, run 0, request flag 1, type 1, request flag 0, type 0.
- R3: A run bit changes only on a register write, and tmr_run drives its value from the cycle after the write.
- R4: An overflow pulse sets that timer's flag on the next cycle. A timer acknowledge pulse clears the flag, and an acknowledge to a flag that is already clear leaves it clear.
- R5: A register write sets or clears each overflow flag to the value written in its bit position.
- R6: When an overflow pulse arrives in the same cycle as a software clear or an acknowledge of the same flag, the flag ends up set.
- R7: With type bit 1 (edge mode), a falling edge on the synchronized pin sets the request flag. The flag stays set after the pin returns high and clears on the acknowledge for that input. A pin held low after the acknowledge does not set the flag again.
- R8: With type bit 0 (level mode), the request flag is 1 while the synchronized pin is low and 0 while it is high. An acknowledge has no effect on it.
- R9: Register writes to the request-flag bit positions (bits 3 and 1) are ignored.
- R10: A write to any address other than 0x88 changes no register bit.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| ovf_pulse | input | 2 | One-cycle overflow pulse per timer |
| irq_pin_n | input | 2 | Asynchronous active-low external interrupt pins |
| tmr_ack | input | 2 | Acknowledge pulse per timer interrupt |
| ext_ack | input | 2 | Acknowledge pulse per external interrupt |
| tmr_run | output | 2 | Timer run enables |
| tmr_flag | output | 2 | Timer overflow flags |
| ext_flag | output | 2 | External interrupt request flags |
| rd_data | output | 8 | Register readback |

## Verification
The bench applies an overflow pulse in the same cycle as a software clear, and again in the same cycle as an acknowledge. A design with the wrong priority would lose that overflow event. In edge mode it holds the pin low through and after the acknowledge. A detector that treats a low level as an edge would raise the request again. In level mode it acknowledges while the pin is still low, which a design sharing the edge clear logic would wrongly drop. Writes to the read-only request bits and to a neighbouring address are also checked; a loose address decode or write mask would corrupt the register.

// File: rtl/tic_pkg.sv
package tic_pkg;
    localparam int NCH = 2;
    localparam int REG_W = 8;
    localparam logic [REG_W-1:0] CTL_ADDR = 8'h88;

    typedef struct packed {
        logic [NCH-1:0] run;
        logic [NCH-1:0] itype;
    } ctl_t;
endpackage

// File: rtl/tic_pin_sync.sv
module tic_pin_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_a,
    output logic [WIDTH-1:0] pin_s
);
    logic [WIDTH-1:0][STAGES-1:0] sh_d, sh_q;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            sh_d[i] = {sh_q[i][STAGES-2:0], pin_a[i]};
        end
        assign pin_s[i] = sh_q[i][STAGES-1];
    end

    // pins idle high, so the chain resets to ones
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/tic_ext_req.sv
module tic_ext_req (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,      // synchronized, active low
    input  logic edge_mode,  // 1: falling edge, 0: low level
    input  logic ack,
    output logic flag
);
    typedef struct packed {
        logic prev;
        logic flag;
    } st_t;

    st_t st_d, st_q;
    logic fall;

    assign fall = st_q.prev & ~pin_s;

    always_comb begin
        st_d      = st_q;
        st_d.prev = pin_s;
        if (edge_mode) begin
            if (fall)     st_d.flag = 1'b1;
            else if (ack) st_d.flag = 1'b0;
        end else begin
            st_d.flag = ~pin_s;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{prev: 1'b1, flag: 1'b0};
        else        st_q <= st_d;
    end

    assign flag = st_q.flag;

    // R7
    edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && st_q.prev && !pin_s |=> flag);
    // R7
    edge_ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        edge_mode && ack && !(st_q.prev && !pin_s) |=> !flag);
    // R8
    level_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode && !pin_s |=> flag);
    // R8
    level_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !edge_mode && pin_s |=> !flag);
endmodule

// File: rtl/tic_ovf_flag.sv
module tic_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf,
    input  logic sw_we,
    input  logic sw_val,
    input  logic ack,
    output logic flag
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (ovf)        flag_d = 1'b1;   // hardware set has priority
        else if (sw_we) flag_d = sw_val;
        else if (ack)   flag_d = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign flag = flag_q;

    // R4 R6
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> flag);
    // R4
    ack_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !ovf && !sw_we |=> !flag);
    // R5
    sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_we && !ovf |=> flag == $past(sw_val));
endmodule

// File: rtl/tmr_irq_ctl.sv
module tmr_irq_ctl
    import tic_pkg::*;
#(
    parameter logic [7:0] ADDR        = CTL_ADDR,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_addr,
    input  logic [7:0] wr_data,
    input  logic [1:0] ovf_pulse,
    input  logic [1:0] irq_pin_n,
    input  logic [1:0] tmr_ack,
    input  logic [1:0] ext_ack,
    output logic [1:0] tmr_run,
    output logic [1:0] tmr_flag,
    output logic [1:0] ext_flag,
    output logic [7:0] rd_data
);
    // bit positions inside the register, per channel
    localparam int TF_BIT [NCH] = '{5, 7};
    localparam int TR_BIT [NCH] = '{4, 6};
    localparam int IT_BIT [NCH] = '{0, 2};

    ctl_t ctl_d, ctl_q;
    logic wr_hit;
    logic [NCH-1:0] pin_s;

    assign wr_hit = wr_en && (wr_addr == ADDR);

    tic_pin_sync #(.WIDTH(NCH), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_a (irq_pin_n),
        .pin_s (pin_s)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (wr_hit) begin
            for (int i = 0; i < NCH; i++) begin
                ctl_d.run[i]   = wr_data[TR_BIT[i]];
                ctl_d.itype[i] = wr_data[IT_BIT[i]];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tic_ovf_flag ovf_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .ovf    (ovf_pulse[i]),
            .sw_we  (wr_hit),
            .sw_val (wr_data[TF_BIT[i]]),
            .ack    (tmr_ack[i]),
            .flag   (tmr_flag[i])
        );

        tic_ext_req ext_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_s[i]),
            .edge_mode (ctl_q.itype[i]),
            .ack       (ext_ack[i]),
            .flag      (ext_flag[i])
        );
    end

    assign tmr_run = ctl_q.run;
    assign rd_data = {tmr_flag[1], ctl_q.run[1], tmr_flag[0], ctl_q.run[0],
                      ext_flag[1], ctl_q.itype[1], ext_flag[0], ctl_q.itype[0]};

    // R3 R10
    run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(tmr_run));
    // R3
    run_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> tmr_run == {$past(wr_data[6]), $past(wr_data[4])});
endmodule

// File: tb/tmr_irq_ctl_tb_top.sv
module tmr_irq_ctl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic [1:0] ovf_pulse = 2'b00;
    logic [1:0] irq_pin_n = 2'b11;
    logic [1:0] tmr_ack = 2'b00;
    logic [1:0] ext_ack = 2'b00;
    logic [1:0] tmr_run, tmr_flag, ext_flag;
    logic [7:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    tmr_irq_ctl dut_i (
        .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .ovf_pulse, .irq_pin_n,
        .tmr_ack, .ext_ack, .tmr_run, .tmr_flag, .ext_flag, .rd_data
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        check("R1 rd_data", rd_data, 8'h00);
        check("R1 outputs", {2'b0, tmr_run, tmr_flag, ext_flag}, 8'h00);
    endtask

    task automatic t_run();
        wr(8'h88, 8'h10);
        check("R3 run0", {6'b0, tmr_run}, 8'h01);
        check("R2 run0 pos", rd_data, 8'h10);
        wr(8'h88, 8'h40);
        check("R3 run1", {6'b0, tmr_run}, 8'h02);
        idle(2);
        check("R3 run hold", {6'b0, tmr_run}, 8'h02);
        wr(8'h88, 8'h00);
        check("R3 run off", {6'b0, tmr_run}, 8'h00);
    endtask

    task automatic t_ovf();
        ovf_pulse = 2'b10; idle(1); ovf_pulse = 2'b00;
        check("R4 ovf set", {6'b0, tmr_flag}, 8'h02);
        check("R2 tf1 pos", rd_data, 8'h80);
        idle(2);
        check("R4 ovf hold", {6'b0, tmr_flag}, 8'h02);
        tmr_ack = 2'b10; idle(1); tmr_ack = 2'b00;
        check("R4 ack clr", {6'b0, tmr_flag}, 8'h00);
        tmr_ack = 2'b01; idle(1); tmr_ack = 2'b00;
        check("R4 ack on clear", {6'b0, tmr_flag}, 8'h00);
    endtask

    task automatic t_sw();
        wr(8'h88, 8'h20);
        check("R5 sw set", {6'b0, tmr_flag}, 8'h01);
        check("R2 tf0 pos", rd_data, 8'h20);
        wr(8'h88, 8'h00);
        check("R5 sw clr", {6'b0, tmr_flag}, 8'h00);
    endtask

    task automatic t_race();
        ovf_pulse = 2'b01;
        wr(8'h88, 8'h00);
        ovf_pulse = 2'b00;
        check("R6 hw vs sw clr", {6'b0, tmr_flag}, 8'h01);
        ovf_pulse = 2'b01; tmr_ack = 2'b01; idle(1);
        ovf_pulse = 2'b00; tmr_ack = 2'b00;
        check("R6 hw vs ack", {6'b0, tmr_flag}, 8'h01);
        wr(8'h88, 8'h00);
    endtask

    task automatic t_edge();
        wr(8'h88, 8'h01);
        irq_pin_n[0] = 1'b0; idle(4);
        check("R7 edge set", {6'b0, ext_flag}, 8'h01);
        check("R2 ie0 pos", rd_data, 8'h03);
        irq_pin_n[0] = 1'b1; idle(4);
        check("R7 edge hold", {6'b0, ext_flag}, 8'h01);
        ext_ack = 2'b01; idle(1); ext_ack = 2'b00;
        check("R7 edge ack", {6'b0, ext_flag}, 8'h00);
        irq_pin_n[0] = 1'b0; idle(4);
        check("R7 second edge", {6'b0, ext_flag}, 8'h01);
        ext_ack = 2'b01; idle(1); ext_ack = 2'b00;
        idle(3);
        check("R7 held low no reset", {6'b0, ext_flag}, 8'h00);
        irq_pin_n[0] = 1'b1; idle(4);
        wr(8'h88, 8'h00);
    endtask

    task automatic t_level();
        irq_pin_n[1] = 1'b0; idle(4);
        check("R8 level low", {6'b0, ext_flag}, 8'h02);
        check("R2 ie1 pos", rd_data, 8'h08);
        ext_ack = 2'b10; idle(1); ext_ack = 2'b00;
        check("R8 ack ignored", {6'b0, ext_flag}, 8'h02);
        irq_pin_n[1] = 1'b1; idle(4);
        check("R8 level high", {6'b0, ext_flag}, 8'h00);
    endtask

    task automatic t_ro();
        wr(8'h88, 8'h0A);
        idle(1);
        check("R9 req bits ro", rd_data, 8'h00);
    endtask

    task automatic t_addr();
        wr(8'h89, 8'hFF);
        idle(1);
        check("R10 other addr", rd_data, 8'h00);
        wr(8'h08, 8'h50);
        check("R10 alias addr", rd_data, 8'h00);
    endtask

    initial begin
        idle(1);
        t_reset();
        t_run();
        t_ovf();
        t_sw();
        t_race();
        t_edge();
        t_level();
        t_ro();
        t_addr();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule